// File: doc/BRIEF.md
# Center-Aligned PWM Channel with Double-Buffered Compare

This block produces one pair of center-aligned PWM waveforms from a triangular timebase. A counter climbs from zero to a programmed top value and falls back to zero, so one PWM period lasts twice the top value in clock cycles. Two compare thresholds set the outputs. On the rising slope, a match pulls its output low. On the falling slope, a match drives it high again. Each output is therefore high for twice its threshold in cycles, and the high interval is centered on the valley.

Software writes the top value and both thresholds at any time, through a strobe, a 2-bit selector and a data bus. Every write lands in a holding copy. The working copy takes the held value only at the valley, so a waveform never changes shape in mid-period. The block issues a one-cycle interrupt strobe at every valley. A sync output either marks the valley or repeats the incoming sync pulse. When phase loading is enabled, an incoming sync pulse forces the counter to a programmed start value, after which it counts upward.

Top module: `pwm_center_ch`

## Requirements
- R1: While reset is asserted, both PWM outputs are high and the interrupt and sync outputs are low. The reset defaults are a top value of 5000, thresholds of 2500 (50 % duty) and a phase value of 0.
- R2: The counter moves by exactly one per cycle: 0, 1, ..., top, top-1, ..., 1, 0. Interrupt pulses are therefore spaced 2 x top cycles apart.
- R3: Selector code 0 writes the held top value. A new top value first governs the period that begins after the next valley, so the period in progress keeps its old length.
- R4: Output A (threshold selector code 1) goes low on a rising-slope match and high on a falling-slope match, so it is high for 2 x threshold cycles of each period.
- R5: Output B (threshold selector code 2) follows the same rule with its own threshold.
- R6: A threshold written in mid-period leaves the current period unchanged. The new threshold applies from the following period on.
- R7: A write that arrives in the same cycle as the valley is forwarded, and takes effect in the period that this valley opens.
- R8: A threshold equal to the top value holds the output high for the whole period.
- R9: A threshold of zero causes no action at the valley, so the output stays high for the whole period.
- R10: The interrupt output is a single-cycle pulse that appears one cycle after each valley.
- R11: With sync_sel low, sync_out pulses together with the interrupt. With sync_sel high, sync_out repeats sync_in one cycle later and ignores the valley.
- R12: With phase_en high, a sync_in pulse loads the phase value (selector code 3, applied at once) into the counter, and counting continues upward from there.
- R13: With phase_en low, sync_in has no effect on the counter or on the interrupt timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 top, 1 threshold A, 2 threshold B, 3 phase |
| wr_data | input | CW | Write data |
| phase_en | input | 1 | Allow sync_in to load the phase value |
| sync_sel | input | 1 | 0: sync_out marks the valley, 1: sync_out repeats sync_in |
| sync_in | input | 1 | Incoming sync pulse |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| irq | output | 1 | Valley interrupt pulse |
| sync_out | output | 1 | Outgoing sync pulse |

## Verification
Two events can fall in the same cycle: a software write to a holding register, and the valley transfer into the working copy. The bench provokes the clash by placing the write exactly 2 x top - 1 cycles after an observed interrupt pulse, which is the cycle in which the counter sits at zero. It then measures the high time of the next period. If the forwarding path works, the new threshold shows up in that period. If the write misses the transfer, the old duty survives one more period and the check reports it.

// File: rtl/pwm_ctr_pkg.sv
package pwm_ctr_pkg;

  // write target codes on the selector bus
  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_CMP0   = 2'd1,
    SEL_CMP1   = 2'd2,
    SEL_PHASE  = 2'd3
  } reg_sel_e;

  // number of compare channels (output A and output B)
  localparam int NUM_CMP = 2;

endpackage

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank
  import pwm_ctr_pkg::*;
#(
  parameter int W       = 16,
  parameter int NCMP    = NUM_CMP,
  parameter int DEF_PRD = 5000,
  parameter int DEF_CMP = 2500
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [1:0]               wr_sel,
  input  logic [W-1:0]             wr_data,
  input  logic                     zero_evt,
  output logic [W-1:0]             prd_act,
  output logic [NCMP-1:0][W-1:0]   cmp_act,
  output logic [W-1:0]             phase_val
);

  logic [W-1:0]           prd_shd, prd_nxt;
  logic [NCMP-1:0][W-1:0] cmp_shd, cmp_nxt;

  // held copy after this cycle's write; also forwarded to the working copy
  always_comb begin
    prd_nxt = (wr_en && wr_sel == SEL_PERIOD) ? wr_data : prd_shd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prd_shd <= W'(DEF_PRD);
      prd_act <= W'(DEF_PRD);
    end else begin
      prd_shd <= prd_nxt;
      if (zero_evt) prd_act <= prd_nxt;
    end
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    always_comb begin
      cmp_nxt[g] = (wr_en && wr_sel == 2'(g + 1)) ? wr_data : cmp_shd[g];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_shd[g] <= W'(DEF_CMP);
        cmp_act[g] <= W'(DEF_CMP);
      end else begin
        cmp_shd[g] <= cmp_nxt[g];
        if (zero_evt) cmp_act[g] <= cmp_nxt[g];
      end
    end
  end

  // phase value is used directly, no holding stage
  always_ff @(posedge clk) begin
    if (rst) phase_val <= '0;
    else if (wr_en && wr_sel == SEL_PHASE) phase_val <= wr_data;
  end

endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] prd,
  input  logic [W-1:0] phase,
  input  logic         load,
  output logic [W-1:0] cnt,
  output logic         up_now,
  output logic         at_zero
);

  logic dir_q;  // direction of the last step

  // direction of the step taken from the current value; extremes turn it
  always_comb begin
    at_zero = (cnt == '0);
    if (at_zero)        up_now = 1'b1;
    else if (cnt >= prd) up_now = 1'b0;
    else                up_now = dir_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      dir_q <= 1'b1;
    end else if (load) begin
      cnt   <= phase;
      dir_q <= 1'b1;
    end else begin
      dir_q <= up_now;
      cnt   <= up_now ? cnt + W'(1) : cnt - W'(1);
    end
  end

endmodule

// File: rtl/pwm_edge_action.sv
module pwm_edge_action #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic         up_now,
  output logic         pwm
);

  // rising-slope match clears, falling-slope match sets, valley does nothing
  always_ff @(posedge clk) begin
    if (rst) pwm <= 1'b1;
    else if (cnt != '0 && cnt == cmp) pwm <= ~up_now;
  end

endmodule

// File: rtl/pwm_center_ch.sv
module pwm_center_ch
  import pwm_ctr_pkg::*;
#(
  parameter int CW          = 16,
  parameter int DEF_PERIOD  = 5000,
  parameter int DEF_COMPARE = 2500
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          phase_en,
  input  logic          sync_sel,
  input  logic          sync_in,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic          irq,
  output logic          sync_out
);

  localparam int NCMP = NUM_CMP;

  logic [CW-1:0]           prd_act, phase_val, cnt;
  logic [NCMP-1:0][CW-1:0] cmp_act;
  logic                    up_now, at_zero, phase_ld;
  logic [NCMP-1:0]         pwm_v;

  assign phase_ld = phase_en & sync_in;

  pwm_shadow_bank #(
    .W(CW), .NCMP(NCMP), .DEF_PRD(DEF_PERIOD), .DEF_CMP(DEF_COMPARE)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .zero_evt(at_zero), .prd_act(prd_act), .cmp_act(cmp_act),
    .phase_val(phase_val)
  );

  pwm_updown_counter #(.W(CW)) u_cnt (
    .clk(clk), .rst(rst), .prd(prd_act), .phase(phase_val), .load(phase_ld),
    .cnt(cnt), .up_now(up_now), .at_zero(at_zero)
  );

  for (genvar g = 0; g < NCMP; g++) begin : g_out
    pwm_edge_action #(.W(CW)) u_act (
      .clk(clk), .rst(rst), .cnt(cnt), .cmp(cmp_act[g]), .up_now(up_now),
      .pwm(pwm_v[g])
    );
  end

  assign pwm_a = pwm_v[0];
  assign pwm_b = pwm_v[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      sync_out <= 1'b0;
    end else begin
      irq      <= at_zero;
      sync_out <= sync_sel ? sync_in : at_zero;
    end
  end

endmodule

// File: rtl/pwm_center_chk.sv
module pwm_center_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cmp_a,
  input logic          phase_ld,
  input logic          pwm_a,
  input logic          irq,
  input logic          sync_sel,
  input logic          sync_out
);

  // R2
  unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(phase_ld)) |->
      (cnt == $past(cnt) + CW'(1) || cnt == $past(cnt) - CW'(1)));

  // R6
  cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cnt) != '0) |-> $stable(cmp_a));

  // R4
  clear_on_match_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pwm_a) |-> ($past(cnt) == $past(cmp_a) && $past(cnt) != '0));

  // R4
  set_on_match_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_a) |-> ($past(cnt) == $past(cmp_a) && $past(cnt) != '0));

  // R10
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R11
  sync_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sync_sel)) |-> (sync_out == irq));

endmodule

bind pwm_center_ch pwm_center_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt), .cmp_a(cmp_act[0]), .phase_ld(phase_ld),
  .pwm_a(pwm_a), .irq(irq), .sync_sel(sync_sel), .sync_out(sync_out)
);

// File: tb/sim_pwm_center_ch.sv
module sim_pwm_center_ch;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        phase_en = 1'b0;
  logic        sync_sel = 1'b0;
  logic        sync_in = 1'b0;
  logic        pwm_a, pwm_b, irq, sync_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  pwm_center_ch u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .phase_en(phase_en), .sync_sel(sync_sel), .sync_in(sync_in),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .irq(irq), .sync_out(sync_out)
  );

  always #10 clk = ~clk;

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // measures one period from an interrupt cycle; optionally writes in cycle wr_at
  task automatic measure(input int wr_at, input logic [1:0] sel,
                         input logic [15:0] d,
                         output int n, output int ha, output int hb);
    n = 0; ha = 0; hb = 0;
    while (!irq) @(negedge clk);
    do begin
      ha += int'(pwm_a);
      hb += int'(pwm_b);
      if (n == wr_at) begin
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
      end
      n++;
      @(negedge clk);
      wr_en = 1'b0;
    end while (!irq);
  endtask

  task automatic t_reset();
    int n, ha, hb;
    chk("R1 pwm_a in reset", int'(pwm_a), 1);
    chk("R1 pwm_b in reset", int'(pwm_b), 1);
    chk("R1 irq in reset", int'(irq), 0);
    chk("R1 sync_out in reset", int'(sync_out), 0);
    rst = 1'b0;
    // default period; queue top value 20 in mid-period
    measure(100, 2'd0, 16'd20, n, ha, hb);
    chk("R1 R2 default period length", n, 10000);
    chk("R1 default duty A", ha, 5000);
    chk("R1 default duty B", hb, 5000);
  endtask

  task automatic t_shadow();
    int n, ha, hb;
    measure(5, 2'd1, 16'd6, n, ha, hb);
    chk("R3 new top value length", n, 40);
    chk("R6 A keeps old threshold (above top)", ha, 40);
    measure(5, 2'd2, 16'd13, n, ha, hb);
    chk("R4 A high time 2x6", ha, 12);
    chk("R6 B keeps old threshold", hb, 40);
    measure(-1, 2'd0, 16'd0, n, ha, hb);
    chk("R5 B high time 2x13", hb, 26);
    chk("R2 interrupt spacing", n, 40);
  endtask

  task automatic t_valley_write();
    int n, ha, hb;
    // write in the cycle the counter is at zero
    measure(39, 2'd1, 16'd9, n, ha, hb);
    chk("R7 period with the coincident write", ha, 12);
    measure(39, 2'd1, 16'd20, n, ha, hb);
    chk("R7 forwarded threshold 9", ha, 18);
    measure(39, 2'd1, 16'd0, n, ha, hb);
    chk("R8 threshold equal to top", ha, 40);
    measure(-1, 2'd0, 16'd0, n, ha, hb);
    chk("R9 threshold zero", ha, 40);
  endtask

  task automatic t_sync_zero();
    int pulses = 0;
    int diff = 0;
    sync_sel = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < 80; i++) begin
      pulses += int'(irq);
      diff += int'(irq != sync_out);
      @(negedge clk);
    end
    chk("R10 one pulse per period", pulses, 2);
    chk("R11 sync_out marks valley", diff, 0);
  endtask

  task automatic t_sync_pass();
    int k = 0;
    sync_sel = 1'b1;
    phase_en = 1'b0;
    @(negedge clk);
    while (!irq) @(negedge clk);
    sync_in = 1'b1;
    do begin
      @(negedge clk);
      sync_in = 1'b0;
      k++;
      if (k == 1) chk("R11 sync_in repeated", int'(sync_out), 1);
    end while (!irq && k < 1000);
    chk("R13 sync ignored, normal spacing", k, 40);
    chk("R11 no valley pulse in repeat mode", int'(sync_out), 0);
  endtask

  task automatic t_phase();
    int k = 0;
    sync_sel = 1'b0;
    wr(2'd3, 16'd15);
    phase_en = 1'b1;
    while (!irq) @(negedge clk);
    sync_in = 1'b1;
    do begin
      @(negedge clk);
      sync_in = 1'b0;
      k++;
    end while (!irq && k < 1000);
    // load 15, up to 20 in 5, down in 20, interrupt one later
    chk("R12 phase load shifts valley", k, 27);
    phase_en = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_shadow();
    t_valley_write();
    t_sync_zero();
    t_sync_pass();
    t_phase();
    finish_run();
  end

endmodule